// File: doc/BRIEF.md
# Stereo Audio Serial Port with MSB-Justified Capture and LSB-Justified Playback

This block is the device-side serial audio port of a stereo codec. The bit clock and the frame clock come from outside the chip. The block oversamples both of them with its own system clock. The frame clock runs at 64 bit clocks per frame, so each channel gets a 32-slot half-frame. The left channel is sent while the frame clock is high and the right channel while it is low.

In every half-frame the block shifts a 20-bit two's-complement capture word out, MSB first, starting in the first slot. Over the same half-frame it shifts a 20-bit playback word in, MSB first, aligned to the last slot. The two directions are therefore justified differently inside the same 32 slots. Capture words are taken in parallel once per frame. Received playback words are handed over as a left/right pair with a single-cycle strobe.

Top module: `audio_jport`

## Requirements
- R1: After reset, and until the first frame clock edge, `sdOut` is 0, `playValid` is 0 and `playLeft`/`playRight` are 0.
- R2: A half-frame begins with frame clock high for the left channel and low for the right channel. A rising frame clock edge samples both `capLeft` and `capRight`.
- R3: Every frame clock transition restarts the slot count at 0, even when the half-frame before it is cut short. Each bit clock falling edge after that advances the slot by one.
- R4: In slot s, for s from 0 to 19, `sdOut` carries capture bit 19-s (bit 19 is the MSB). It changes within 3 system clocks after the bit clock falling edge that opens the slot.
- R5: In slots 20 to 31 of every half-frame, `sdOut` is driven to 0.
- R6: `sdIn` is sampled on the bit clock rising edge. Slots 0 to 11 are ignored. Playback bit 19 arrives in slot 12 and bit 0 arrives in slot 31.
- R7: After the rising bit clock edge of right slot 31, `playValid` pulses high for exactly one system clock. During that pulse, `playLeft`/`playRight` hold the last complete left word and the right word just received.
- R8: A change on `capRight` after the frame's rising frame clock edge has no effect on the right half-frame sent in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | External bit clock, 64 per frame |
| lrckIn | input | 1 | External frame clock, high = left |
| sdIn | input | 1 | Serial playback data |
| capLeft | input | 20 | Left capture word, two's complement |
| capRight | input | 20 | Right capture word, two's complement |
| sdOut | output | 1 | Serial capture data |
| playLeft | output | 20 | Received left playback word |
| playRight | output | 20 | Received right playback word |
| playValid | output | 1 | One-cycle strobe: playback pair updated |

## Verification
The bench uses capture words at the extremes of the two's-complement range (0x80000, 0x7FFFF), alternating patterns, and single-bit-set words, so that bit reversals and off-by-one slot errors in either direction give different results. It fills the ignored playback slots with ones and with zeros, opposite to the payload's edge bits, which shows whether slots 0 to 11 leak into the word. One frame cuts the left half short after 10 slots and changes `capRight` during it. That frame separates a correct slot restart from a free-running counter, and shows that the stale left word and the latched right capture word are kept.

// File: rtl/audio_jport_pkg.sv
`timescale 1ns/1ps
package audio_jport_pkg;
  localparam int SampleBits = 20;
  localparam int HalfSlots  = 32;
  localparam int SlotW      = $clog2(HalfSlots) + 1;

  typedef struct packed {
    logic             halfStart;  // frame clock changed: new half-frame
    logic             leftHalf;   // level of the new half-frame (1 = left)
    logic             txAdvance;  // bit clock fell inside a half-frame
    logic             rxTake;     // bit clock rose inside the receive window
    logic             rxEnd;      // rxTake in the last slot
    logic             rxLeft;     // current half-frame is left
    logic [SlotW-1:0] slot;       // current slot, HalfSlots = idle
  } ctlStrobes_t;
endpackage

// File: rtl/audio_jport_ctrl.sv
`timescale 1ns/1ps
module audio_jport_ctrl
  import audio_jport_pkg::*;
#(
  parameter int unsigned SLOTS = HalfSlots,
  parameter int unsigned DW    = SampleBits
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bclkIn,
  input  logic        lrckIn,
  output ctlStrobes_t ctl
);
  localparam logic [SlotW-1:0] IdleSlot = SlotW'(SLOTS);
  localparam logic [SlotW-1:0] LastSlot = SlotW'(SLOTS - 1);
  localparam logic [SlotW-1:0] RxFirst  = SlotW'(SLOTS - DW);

  logic bclkQ1, bclkQ2, lrQ1, lrQ2, leftQ;
  logic [SlotW-1:0] slotQ;
  logic lrEdge, bRise, bFall;

  assign lrEdge = lrQ1 ^ lrQ2;
  assign bRise  = bclkQ1 & ~bclkQ2;
  assign bFall  = ~bclkQ1 & bclkQ2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ1 <= 1'b0;
      bclkQ2 <= 1'b0;
      lrQ1   <= 1'b0;
      lrQ2   <= 1'b0;
      leftQ  <= 1'b0;
      slotQ  <= IdleSlot;
    end else begin
      bclkQ1 <= bclkIn;
      bclkQ2 <= bclkQ1;
      lrQ1   <= lrckIn;
      lrQ2   <= lrQ1;
      if (lrEdge) begin
        slotQ <= '0;
        leftQ <= lrQ1;
      end else if (bFall && slotQ != IdleSlot) begin
        slotQ <= slotQ + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.halfStart = lrEdge;
    ctl.leftHalf  = lrQ1;
    ctl.txAdvance = bFall & ~lrEdge;
    ctl.rxTake    = bRise & ~lrEdge & (slotQ >= RxFirst) & (slotQ <= LastSlot);
    ctl.rxEnd     = ctl.rxTake & (slotQ == LastSlot);
    ctl.rxLeft    = leftQ;
    ctl.slot      = slotQ;
  end

  // R3: outside a frame clock edge the slot only holds or steps by one
  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    (!lrEdge && slotQ != IdleSlot) |=> (slotQ == $past(slotQ) || slotQ == $past(slotQ) + 1'b1));
endmodule

// File: rtl/audio_jport_dp.sv
`timescale 1ns/1ps
module audio_jport_dp
  import audio_jport_pkg::*;
#(
  parameter int unsigned DW = SampleBits
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   ctl,
  input  logic          sdIn,
  input  logic [DW-1:0] capLeft,
  input  logic [DW-1:0] capRight,
  output logic          sdOut,
  output logic [DW-1:0] playLeft,
  output logic [DW-1:0] playRight,
  output logic          playValid
);
  logic          sdInQ;
  logic [DW-1:0] txShift, capRightHold, rxShift, leftHold, rxWord;

  assign rxWord = {rxShift[DW-2:0], sdInQ};

  // transmit: MSB-justified, zeros shifted in fill the tail slots
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift      <= '0;
      capRightHold <= '0;
      sdOut        <= 1'b0;
    end else if (ctl.halfStart) begin
      if (ctl.leftHalf) begin
        txShift      <= {capLeft[DW-2:0], 1'b0};
        sdOut        <= capLeft[DW-1];
        capRightHold <= capRight;
      end else begin
        txShift <= {capRightHold[DW-2:0], 1'b0};
        sdOut   <= capRightHold[DW-1];
      end
    end else if (ctl.txAdvance) begin
      sdOut   <= txShift[DW-1];
      txShift <= {txShift[DW-2:0], 1'b0};
    end
  end

  // receive: LSB-justified, only the window slots are shifted in
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdInQ     <= 1'b0;
      rxShift   <= '0;
      leftHold  <= '0;
      playLeft  <= '0;
      playRight <= '0;
      playValid <= 1'b0;
    end else begin
      sdInQ     <= sdIn;
      playValid <= 1'b0;
      if (ctl.rxTake) rxShift <= rxWord;
      if (ctl.rxEnd) begin
        if (ctl.rxLeft) begin
          leftHold <= rxWord;
        end else begin
          playLeft  <= leftHold;
          playRight <= rxWord;
          playValid <= 1'b1;
        end
      end
    end
  end

  // R7: the strobe never lasts more than one cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    playValid |=> !playValid);
endmodule

// File: rtl/audio_jport.sv
`timescale 1ns/1ps
module audio_jport
  import audio_jport_pkg::*;
#(
  parameter int unsigned DW    = SampleBits,
  parameter int unsigned SLOTS = HalfSlots
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bclkIn,
  input  logic          lrckIn,
  input  logic          sdIn,
  input  logic [DW-1:0] capLeft,
  input  logic [DW-1:0] capRight,
  output logic          sdOut,
  output logic [DW-1:0] playLeft,
  output logic [DW-1:0] playRight,
  output logic          playValid
);
  ctlStrobes_t ctl;

  audio_jport_ctrl #(.SLOTS(SLOTS), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrckIn(lrckIn), .ctl(ctl)
  );

  audio_jport_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdIn(sdIn),
    .capLeft(capLeft), .capRight(capRight), .sdOut(sdOut),
    .playLeft(playLeft), .playRight(playRight), .playValid(playValid)
  );

  // R5: tail slots of a half-frame carry zero
  a_r5_tail_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.slot >= SlotW'(DW) && ctl.slot < SlotW'(SLOTS)) |-> !sdOut);

  // R4: serial output moves only on a half-frame start or a bit clock fall
  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.halfStart && !ctl.txAdvance) |=> $stable(sdOut));

  // R7: a strobe follows only the last receive slot of a right half-frame
  a_r7_after_right: assert property (@(posedge clk) disable iff (!rstN)
    $rose(playValid) |-> ($past(ctl.rxEnd) && !$past(ctl.rxLeft)));
endmodule

// File: tb/audio_jport_bench.sv
`timescale 1ns/1ps
module audio_jport_bench;
  localparam int DW = 20;
  localparam int SLOTS = 32;
  localparam int HALFCLK = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, bclkIn, lrckIn, sdIn, sdOut, playValid;
  logic [DW-1:0] capLeft, capRight, playLeft, playRight;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0, prevValid = 0;
  logic [DW-1:0] lastLeft = '0;
  logic [2*DW-1:0] expQ[$];

  audio_jport u_audio_jport (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrckIn(lrckIn), .sdIn(sdIn),
    .capLeft(capLeft), .capRight(capRight), .sdOut(sdOut),
    .playLeft(playLeft), .playRight(playRight), .playValid(playValid)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one half-frame; tag names the requirement for the payload slots
  task automatic runHalf(bit left, logic [DW-1:0] cap, logic [DW-1:0] play, bit noise,
                         int nSlots, bit corruptR, string tag);
    for (int s = 0; s < nSlots; s++) begin
      bclkIn = 1'b0;
      if (s == 0) lrckIn = left;
      sdIn = (s >= SLOTS - DW) ? play[SLOTS-1-s] : noise;
      tick(HALFCLK);
      if (s < DW) check(sdOut === cap[DW-1-s], tag, 64'(sdOut), 64'(cap[DW-1-s]));
      else        check(sdOut === 1'b0, "R5", 64'(sdOut), 64'd0);
      if (corruptR && s == 5) capRight = ~capRight;  // R8 stimulus
      bclkIn = 1'b1;
      tick(HALFCLK);
    end
  endtask

  task automatic sendFrame(logic [DW-1:0] cL, logic [DW-1:0] cR, logic [DW-1:0] pL,
                           logic [DW-1:0] pR, bit noise, int leftSlots, bit corruptR,
                           string tagL, string tagR);
    capLeft = cL;
    capRight = cR;
    tick(2);
    runHalf(1'b1, cL, pL, noise, leftSlots, corruptR, tagL);
    if (leftSlots == SLOTS) lastLeft = pL;
    expQ.push_back({lastLeft, pR});
    runHalf(1'b0, cR, pR, noise, SLOTS, 1'b0, tagR);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && playValid === 1'b1) begin
      strobes++;
      check(!prevValid, "R7", 64'(prevValid), 64'd0);
      if (expQ.size() == 0) begin
        check(1'b0, "R7", 64'd1, 64'd0);
      end else begin
        logic [2*DW-1:0] e;
        e = expQ.pop_front();
        check(playLeft === e[2*DW-1:DW], "R6", 64'(playLeft), 64'(e[2*DW-1:DW]));
        check(playRight === e[DW-1:0], "R6", 64'(playRight), 64'(e[DW-1:0]));
      end
    end
    prevValid = (playValid === 1'b1);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; bclkIn = 1'b1; lrckIn = 1'b0; sdIn = 1'b0;
    capLeft = '0; capRight = '0;
    tick(5);
    check(sdOut === 1'b0, "R1", 64'(sdOut), 64'd0);
    check(playValid === 1'b0, "R1", 64'(playValid), 64'd0);
    check(playLeft === '0 && playRight === '0, "R1", 64'({playLeft, playRight}), 64'd0);
    rstN = 1'b1;
    capLeft = 20'hFFFFF;
    // R1: bit clock runs with no frame clock edge yet
    for (int i = 0; i < 10; i++) begin
      bclkIn = 1'b0; sdIn = 1'b1; tick(HALFCLK);
      check(sdOut === 1'b0, "R1", 64'(sdOut), 64'd0);
      bclkIn = 1'b1; tick(HALFCLK);
    end
    check(strobes == 0, "R1", 64'(strobes), 64'd0);

    sendFrame(20'h80000, 20'h7FFFF, 20'h12345, 20'hABCDE, 1'b1, SLOTS, 1'b0, "R4", "R2");
    sendFrame(20'hAAAAA, 20'h55555, 20'h55555, 20'hAAAAA, 1'b0, SLOTS, 1'b0, "R4", "R4");
    sendFrame(20'hFFFFF, 20'h00001, 20'h80001, 20'h7FFFE, 1'b1, SLOTS, 1'b0, "R2", "R4");
    // R3 and R8: left half cut after 10 slots, capRight changed mid-left
    sendFrame(20'h13579, 20'h2468A, 20'hFFFFF, 20'h0F0F0, 1'b0, 10, 1'b1, "R3", "R8");
    // R6: ignored slots full of ones around an all-zero payload
    sendFrame(20'h00000, 20'hFFFFF, 20'h00000, 20'hFFFFF, 1'b1, SLOTS, 1'b0, "R4", "R4");
    tick(20);
    check(expQ.size() == 0, "R7", 64'(expQ.size()), 64'd0);
    check(strobes == 5, "R7", 64'(strobes), 64'd5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule